// File: doc/BRIEF.md
# Multithreaded Commit Squash Controller

This block sits beside a multithreaded reorder buffer and decides, cycle by cycle, which hardware threads must discard their in-flight instructions and back to which sequence number. It keeps one status value per thread. Three kinds of request can start a squash. A trap request does not act at once: it waits for a programmable number of cycles first. A context request squashes the whole thread. An execute-stage request carries the sequence number of the instruction that found the problem, plus its own redirect PC.

When a thread squashes, the block emits a one-cycle pulse with a rollback sequence number, a redirect PC and a mispredict bit. It also raises a per-thread "reorder buffer is squashing" flag. That flag stays up until the buffer reports that it has drained. The block tracks the youngest valid sequence number of each thread, so that a squash from a younger instruction can never undo a squash from an older one. When every thread is squashing at the same time, instruction intake is shut off. The reorder buffer storage, the pipeline stages and the trap handler are outside the block. Per-thread head, empty and done inputs stand in for them.

Top module: `thread_squash_ctrl`

## Requirements
- R1: Each thread's `thr_status` field uses the code 0 Idle, 1 Running, 2 Squashing, 3 TrapWait, 4 FetchTrapWait. Reset puts every thread in Idle with no pulse, no squashing flag and a zero mispredict count. An accepted allocation (`alloc_valid`, while `intake_en` is high and the thread is Idle or Running) records `alloc_seq` as the thread's youngest sequence number and moves an Idle thread to Running.
- R2: A trap request taken at clock edge E loads a timer with `trap_lat` (a value of 0 counts as 1). The squash pulse appears after edge E+L+1. Until then the thread sits in TrapWait, or in FetchTrapWait when `trap_fetch` is high, and it produces no squash.
- R3: If a trap squash and a context squash are pending on one thread in the same cycle, the trap squash is serviced first and `both_err` is raised for that cycle. The context squash is serviced in the following cycle.
- R4: A trap or context squash uses rollback number `rob_head_seq`-1, or 0 when `rob_empty` is high. Its redirect PC is `arch_pc`, and it resets the thread's youngest sequence number to 0.
- R5: An execute-stage squash is accepted only when the thread is not in TrapWait or FetchTrapWait and `ex_sq_seq` is less than or equal to the thread's youngest sequence number. A rejected request produces no pulse and leaves the status unchanged.
- R6: An accepted execute-stage squash outputs rollback `ex_sq_seq`, minus one when `ex_sq_incl` is high, together with `ex_sq_pc`. That rollback becomes the thread's youngest sequence number. All squash outputs appear one clock after the request is sampled.
- R7: A squashing thread stays in Squashing, with `rob_squashing` high in every cycle, until `rob_done` is sampled high. It then returns to Running.
- R8: `squash_count` equals the number of threads in Squashing. `intake_en` is low exactly when all threads are squashing.
- R9: `sq_mispred` copies `ex_sq_mispred` for execute-stage squashes and is 0 for trap and context squashes. `mispred_cnt` grows by one for each accepted squash that has the mispredict bit set.
- R10: A trap request is ignored while the thread is waiting on a trap or is squashing. A repeated request does not restart the running timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_lat | input | LAT_W | Trap delay in cycles |
| trap_req | input | NTHR | Per-thread trap request |
| trap_fetch | input | NTHR | Trap originates from fetch (selects FetchTrapWait) |
| ctx_sq_req | input | NTHR | Per-thread context squash request |
| ex_sq_valid | input | NTHR | Execute-stage squash request |
| ex_sq_seq | input | NTHR*SEQ_W | Sequence number of the squashing instruction |
| ex_sq_incl | input | NTHR | Squash includes the squashing instruction |
| ex_sq_mispred | input | NTHR | Squash caused by branch mispredict |
| ex_sq_pc | input | NTHR*PC_W | Redirect PC from execute |
| alloc_valid | input | NTHR | Instruction allocated into the buffer |
| alloc_seq | input | NTHR*SEQ_W | Sequence number of the allocated instruction |
| rob_empty | input | NTHR | Thread has no buffer entries |
| rob_head_seq | input | NTHR*SEQ_W | Sequence number at buffer head |
| rob_done | input | NTHR | Buffer has finished squashing |
| arch_pc | input | NTHR*PC_W | Restart PC for trap and context squashes |
| sq_pulse | output | NTHR | One-cycle squash indication |
| sq_seq | output | NTHR*SEQ_W | Rollback sequence number |
| sq_pc | output | NTHR*PC_W | Redirect PC |
| sq_mispred | output | NTHR | Squash is a mispredict |
| rob_squashing | output | NTHR | Buffer squash in progress |
| thr_status | output | NTHR*3 | Per-thread status code |
| both_err | output | NTHR | Trap and context squash collided |
| squash_count | output | CNT_W | Number of squashing threads |
| intake_en | output | 1 | Instruction intake allowed |
| mispred_cnt | output | MISP_W | Accepted mispredict squashes |

## Verification
Most wrong internal state becomes visible within one or two clocks. A youngest-sequence register holding the wrong value shows up the next time an execute squash probes it: a request that should be accepted gives no pulse, or a request that should be dropped gives one. A trap timer that is off by one moves the trap pulse by a cycle, so the check samples exactly the cycle after L+1 edges and also the cycles before it. A stale squashing status shows up at once as a mismatch between `rob_squashing`, `squash_count` and `intake_en`.

// File: rtl/sqc_pkg.sv
package sqc_pkg;

    localparam int TSTATE_W = 3;

    typedef enum logic [TSTATE_W-1:0] {
        TS_IDLE   = 3'd0,
        TS_RUN    = 3'd1,
        TS_SQUASH = 3'd2,
        TS_TRAPW  = 3'd3,
        TS_FTRAPW = 3'd4
    } tstate_e;

    // Kind of squash chosen for a thread in one cycle.
    typedef struct packed {
        logic full;   // trap or context squash
        logic exec;   // accepted execute-stage squash
    } sq_kind_t;

    function automatic logic waits_trap(tstate_e s);
        return (s == TS_TRAPW) || (s == TS_FTRAPW);
    endfunction

    function automatic logic is_live(tstate_e s);
        return (s == TS_IDLE) || (s == TS_RUN);
    endfunction

endpackage

// File: rtl/sqc_trap_timer.sv
module sqc_trap_timer #(
    parameter int LAT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic [LAT_W-1:0] lat,
    input  logic             consume,
    output logic             fire,
    output logic             busy
);
    logic [LAT_W-1:0] cnt_q;
    logic             fire_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            fire_q <= 1'b0;
        end else begin
            if (arm)
                cnt_q <= (lat == '0) ? LAT_W'(1) : lat;
            else if (cnt_q != '0)
                cnt_q <= cnt_q - LAT_W'(1);

            if (consume)
                fire_q <= 1'b0;
            if (!arm && cnt_q == LAT_W'(1))
                fire_q <= 1'b1;
        end
    end

    assign fire = fire_q;
    assign busy = (cnt_q != '0) || fire_q;
endmodule

// File: rtl/sqc_thread_unit.sv
module sqc_thread_unit
    import sqc_pkg::*;
#(
    parameter int SEQ_W = 16,
    parameter int PC_W  = 32,
    parameter int LAT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             intake_en,
    input  logic             trap_req,
    input  logic             trap_fetch,
    input  logic [LAT_W-1:0] trap_lat,
    input  logic             ctx_req,
    input  logic             ex_valid,
    input  logic [SEQ_W-1:0] ex_seq,
    input  logic             ex_incl,
    input  logic             ex_mispred,
    input  logic [PC_W-1:0]  ex_pc,
    input  logic             alloc_valid,
    input  logic [SEQ_W-1:0] alloc_seq,
    input  logic             rob_empty,
    input  logic [SEQ_W-1:0] rob_head_seq,
    input  logic             rob_done,
    input  logic [PC_W-1:0]  arch_pc,
    output logic             sq_pulse,
    output logic [SEQ_W-1:0] sq_seq,
    output logic [PC_W-1:0]  sq_pc,
    output logic             sq_mispred,
    output logic             rob_squashing,
    output logic [TSTATE_W-1:0] status,
    output logic             both_err,
    output logic             mis_now
);
    typedef struct packed {
        logic             pulse;
        logic [SEQ_W-1:0] seq;
        logic [PC_W-1:0]  pc;
        logic             mis;
    } sq_rec_t;

    tstate_e          st_q, st_a, st_b, st_n;
    logic [SEQ_W-1:0] yg_q, yg_b, yg_n;
    logic             ctx_q;
    logic             tmr_fire, tmr_busy, arm;
    logic             alloc_ok;
    sq_kind_t         kind;
    sq_rec_t          rec_q, rec_n;
    logic             rsq_q, both_q;

    sqc_trap_timer #(.LAT_W(LAT_W)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .arm     (arm),
        .lat     (trap_lat),
        .consume (tmr_fire),
        .fire    (tmr_fire),
        .busy    (tmr_busy)
    );

    always_comb begin
        // Buffer drain completes before new squashes are judged.
        st_a = (st_q == TS_SQUASH && rob_done) ? TS_RUN : st_q;

        kind.full = tmr_fire | ctx_q;
        st_b      = kind.full ? TS_SQUASH : st_a;
        yg_b      = kind.full ? '0 : yg_q;

        kind.exec = ex_valid && !waits_trap(st_b) && (ex_seq <= yg_b);

        rec_n = rec_q;
        rec_n.pulse = kind.full | kind.exec;
        rec_n.mis   = 1'b0;
        if (kind.exec) begin
            rec_n.seq = ex_seq - SEQ_W'(ex_incl);
            rec_n.pc  = ex_pc;
            rec_n.mis = ex_mispred;
        end else if (kind.full) begin
            rec_n.seq = rob_empty ? '0 : (rob_head_seq - SEQ_W'(1));
            rec_n.pc  = arch_pc;
        end

        arm      = trap_req && !rec_n.pulse && is_live(st_b) && !tmr_busy;
        alloc_ok = intake_en && alloc_valid && !rec_n.pulse && is_live(st_b);

        st_n = st_b;
        yg_n = yg_b;
        if (kind.exec) begin
            st_n = TS_SQUASH;
            yg_n = rec_n.seq;
        end
        if (alloc_ok) begin
            yg_n = alloc_seq;
            if (st_b == TS_IDLE)
                st_n = TS_RUN;
        end
        if (arm)
            st_n = trap_fetch ? TS_FTRAPW : TS_TRAPW;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= TS_IDLE;
            yg_q   <= '0;
            ctx_q  <= 1'b0;
            rec_q  <= '0;
            rsq_q  <= 1'b0;
            both_q <= 1'b0;
        end else begin
            st_q   <= st_n;
            yg_q   <= yg_n;
            // Trap wins; a colliding context squash waits one cycle.
            if (ctx_req)
                ctx_q <= 1'b1;
            else if (ctx_q && !tmr_fire)
                ctx_q <= 1'b0;
            rec_q  <= rec_n;
            rsq_q  <= rec_n.pulse | (st_a == TS_SQUASH);
            both_q <= tmr_fire & ctx_q;
        end
    end

    assign sq_pulse      = rec_q.pulse;
    assign sq_seq        = rec_q.seq;
    assign sq_pc         = rec_q.pc;
    assign sq_mispred    = rec_q.mis;
    assign rob_squashing = rsq_q;
    assign status        = st_q;
    assign both_err      = both_q;
    assign mis_now       = kind.exec & ex_mispred;
endmodule

// File: rtl/sqc_tally.sv
module sqc_tally
    import sqc_pkg::*;
#(
    parameter int NTHR   = 2,
    parameter int CNT_W  = 2,
    parameter int MISP_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NTHR*TSTATE_W-1:0] status_flat,
    input  logic [NTHR-1:0]          mis_now,
    output logic [CNT_W-1:0]         squash_count,
    output logic                     intake_en,
    output logic [MISP_W-1:0]        mispred_cnt
);
    logic [CNT_W-1:0]  sq_cnt;
    logic [MISP_W-1:0] mis_add;
    logic [MISP_W-1:0] mcnt_q;

    always_comb begin
        sq_cnt  = '0;
        mis_add = '0;
        for (int t = 0; t < NTHR; t++) begin
            if (status_flat[t*TSTATE_W +: TSTATE_W] == TS_SQUASH)
                sq_cnt = sq_cnt + CNT_W'(1);
            if (mis_now[t])
                mis_add = mis_add + MISP_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            mcnt_q <= '0;
        else
            mcnt_q <= mcnt_q + mis_add;
    end

    assign squash_count = sq_cnt;
    assign intake_en    = (sq_cnt != CNT_W'(NTHR));
    assign mispred_cnt  = mcnt_q;
endmodule

// File: rtl/thread_squash_ctrl.sv
module thread_squash_ctrl
    import sqc_pkg::*;
#(
    parameter int NTHR   = 2,
    parameter int SEQ_W  = 16,
    parameter int PC_W   = 32,
    parameter int LAT_W  = 4,
    parameter int MISP_W = 8,
    parameter int CNT_W  = $clog2(NTHR + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [LAT_W-1:0]         trap_lat,
    input  logic [NTHR-1:0]          trap_req,
    input  logic [NTHR-1:0]          trap_fetch,
    input  logic [NTHR-1:0]          ctx_sq_req,
    input  logic [NTHR-1:0]          ex_sq_valid,
    input  logic [NTHR*SEQ_W-1:0]    ex_sq_seq,
    input  logic [NTHR-1:0]          ex_sq_incl,
    input  logic [NTHR-1:0]          ex_sq_mispred,
    input  logic [NTHR*PC_W-1:0]     ex_sq_pc,
    input  logic [NTHR-1:0]          alloc_valid,
    input  logic [NTHR*SEQ_W-1:0]    alloc_seq,
    input  logic [NTHR-1:0]          rob_empty,
    input  logic [NTHR*SEQ_W-1:0]    rob_head_seq,
    input  logic [NTHR-1:0]          rob_done,
    input  logic [NTHR*PC_W-1:0]     arch_pc,
    output logic [NTHR-1:0]          sq_pulse,
    output logic [NTHR*SEQ_W-1:0]    sq_seq,
    output logic [NTHR*PC_W-1:0]     sq_pc,
    output logic [NTHR-1:0]          sq_mispred,
    output logic [NTHR-1:0]          rob_squashing,
    output logic [NTHR*TSTATE_W-1:0] thr_status,
    output logic [NTHR-1:0]          both_err,
    output logic [CNT_W-1:0]         squash_count,
    output logic                     intake_en,
    output logic [MISP_W-1:0]        mispred_cnt
);
    logic [NTHR-1:0] mis_now;

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        sqc_thread_unit #(.SEQ_W(SEQ_W), .PC_W(PC_W), .LAT_W(LAT_W)) u_unit (
            .clk           (clk),
            .rst           (rst),
            .intake_en     (intake_en),
            .trap_req      (trap_req[t]),
            .trap_fetch    (trap_fetch[t]),
            .trap_lat      (trap_lat),
            .ctx_req       (ctx_sq_req[t]),
            .ex_valid      (ex_sq_valid[t]),
            .ex_seq        (ex_sq_seq[t*SEQ_W +: SEQ_W]),
            .ex_incl       (ex_sq_incl[t]),
            .ex_mispred    (ex_sq_mispred[t]),
            .ex_pc         (ex_sq_pc[t*PC_W +: PC_W]),
            .alloc_valid   (alloc_valid[t]),
            .alloc_seq     (alloc_seq[t*SEQ_W +: SEQ_W]),
            .rob_empty     (rob_empty[t]),
            .rob_head_seq  (rob_head_seq[t*SEQ_W +: SEQ_W]),
            .rob_done      (rob_done[t]),
            .arch_pc       (arch_pc[t*PC_W +: PC_W]),
            .sq_pulse      (sq_pulse[t]),
            .sq_seq        (sq_seq[t*SEQ_W +: SEQ_W]),
            .sq_pc         (sq_pc[t*PC_W +: PC_W]),
            .sq_mispred    (sq_mispred[t]),
            .rob_squashing (rob_squashing[t]),
            .status        (thr_status[t*TSTATE_W +: TSTATE_W]),
            .both_err      (both_err[t]),
            .mis_now       (mis_now[t])
        );
    end

    sqc_tally #(.NTHR(NTHR), .CNT_W(CNT_W), .MISP_W(MISP_W)) u_tally (
        .clk          (clk),
        .rst          (rst),
        .status_flat  (thr_status),
        .mis_now      (mis_now),
        .squash_count (squash_count),
        .intake_en    (intake_en),
        .mispred_cnt  (mispred_cnt)
    );
endmodule

// File: rtl/sqc_checker.sv
module sqc_checker
    import sqc_pkg::*;
#(
    parameter int NTHR   = 2,
    parameter int CNT_W  = 2,
    parameter int MISP_W = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic [NTHR-1:0]          ex_sq_valid,
    input logic [NTHR-1:0]          ex_sq_mispred,
    input logic [NTHR-1:0]          sq_pulse,
    input logic [NTHR-1:0]          sq_mispred,
    input logic [NTHR-1:0]          rob_squashing,
    input logic [NTHR*TSTATE_W-1:0] thr_status,
    input logic [NTHR-1:0]          both_err,
    input logic [CNT_W-1:0]         squash_count,
    input logic                     intake_en,
    input logic [MISP_W-1:0]        mispred_cnt
);
    logic [NTHR-1:0] in_sq;

    for (genvar t = 0; t < NTHR; t++) begin : g_chk
        logic [TSTATE_W-1:0] st;
        assign st       = thr_status[t*TSTATE_W +: TSTATE_W];
        assign in_sq[t] = (st == TS_SQUASH);

        AST_STATUS_CODE: assert property (@(posedge clk) disable iff (rst)
            st <= 3'd4);                                                  // R1
        AST_TRAPWAIT_QUIET: assert property (@(posedge clk) disable iff (rst)
            (st == TS_TRAPW || st == TS_FTRAPW) |-> !sq_pulse[t]);        // R2
        AST_COLLIDE_TRAP_FIRST: assert property (@(posedge clk) disable iff (rst)
            both_err[t] |-> (sq_pulse[t] && !sq_mispred[t]));             // R3
        AST_MISPRED_FROM_EXEC: assert property (@(posedge clk) disable iff (rst)
            sq_mispred[t] |-> $past(ex_sq_valid[t] && ex_sq_mispred[t])); // R9
        AST_FLAG_MEANS_SQUASH: assert property (@(posedge clk) disable iff (rst)
            rob_squashing[t] |-> (st == TS_SQUASH));                      // R7
        AST_PULSE_RAISES_FLAG: assert property (@(posedge clk) disable iff (rst)
            sq_pulse[t] |-> rob_squashing[t]);                            // R6
    end

    AST_INTAKE_GATE: assert property (@(posedge clk) disable iff (rst)
        intake_en == !(&rob_squashing));                                  // R8
    AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (rst)
        squash_count == CNT_W'($countones(in_sq)));                       // R8
    AST_MISP_STEP: assert property (@(posedge clk) disable iff (rst)
        (mispred_cnt != $past(mispred_cnt)) |-> (|sq_mispred));           // R9
endmodule

bind thread_squash_ctrl sqc_checker #(
    .NTHR(NTHR), .CNT_W(CNT_W), .MISP_W(MISP_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .ex_sq_valid   (ex_sq_valid),
    .ex_sq_mispred (ex_sq_mispred),
    .sq_pulse      (sq_pulse),
    .sq_mispred    (sq_mispred),
    .rob_squashing (rob_squashing),
    .thr_status    (thr_status),
    .both_err      (both_err),
    .squash_count  (squash_count),
    .intake_en     (intake_en),
    .mispred_cnt   (mispred_cnt)
);

// File: tb/thread_squash_ctrl_bench.sv
`timescale 1ns/1ps
module thread_squash_ctrl_bench;
    localparam int NTHR = 2, SEQ_W = 16, PC_W = 32, LAT_W = 4, MISP_W = 8;
    localparam int CNT_W = $clog2(NTHR + 1);

    logic clk = 1'b0, rst = 1'b1;
    logic [LAT_W-1:0] trap_lat = '0;
    logic [NTHR-1:0] trap_req = '0, trap_fetch = '0, ctx_sq_req = '0;
    logic [NTHR-1:0] ex_sq_valid = '0, ex_sq_incl = '0, ex_sq_mispred = '0;
    logic [NTHR*SEQ_W-1:0] ex_sq_seq = '0, alloc_seq = '0, rob_head_seq = '0;
    logic [NTHR*PC_W-1:0] ex_sq_pc = '0, arch_pc = '0;
    logic [NTHR-1:0] alloc_valid = '0, rob_empty = '0, rob_done = '1;
    logic [NTHR-1:0] sq_pulse, sq_mispred, rob_squashing, both_err;
    logic [NTHR*SEQ_W-1:0] sq_seq;
    logic [NTHR*PC_W-1:0] sq_pc;
    logic [NTHR*3-1:0] thr_status;
    logic [CNT_W-1:0] squash_count;
    logic intake_en;
    logic [MISP_W-1:0] mispred_cnt;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    thread_squash_ctrl #(.NTHR(NTHR), .SEQ_W(SEQ_W), .PC_W(PC_W),
        .LAT_W(LAT_W), .MISP_W(MISP_W)) u_thread_squash_ctrl (.*);

    task automatic check(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic longint st(int t);  return thr_status[t*3 +: 3];      endfunction
    function automatic longint sseq(int t); return sq_seq[t*SEQ_W +: SEQ_W]; endfunction
    function automatic longint spc(int t); return sq_pc[t*PC_W +: PC_W];     endfunction

    task automatic exsq(int t, int seq, bit incl, bit mis, int pc);
        ex_sq_valid[t] = 1'b1;
        ex_sq_seq[t*SEQ_W +: SEQ_W] = SEQ_W'(seq);
        ex_sq_incl[t] = incl;
        ex_sq_mispred[t] = mis;
        ex_sq_pc[t*PC_W +: PC_W] = PC_W'(pc);
    endtask

    task automatic alloc(int t, int seq);
        alloc_valid[t] = 1'b1;
        alloc_seq[t*SEQ_W +: SEQ_W] = SEQ_W'(seq);
        tick();
        alloc_valid[t] = 1'b0;
    endtask

    task automatic t_reset();
        for (int t = 0; t < NTHR; t++) check("R1", "reset status", st(t), 0);
        check("R1", "reset pulse", sq_pulse, 0);
        check("R1", "reset flag", rob_squashing, 0);
        check("R8", "reset intake", intake_en, 1);
        check("R9", "reset mcnt", mispred_cnt, 0);
    endtask

    task automatic t_exec_age();
        alloc(0, 10);
        check("R1", "alloc running", st(0), 1);
        exsq(0, 12, 0, 1, 'h50); tick(); ex_sq_valid = '0;
        check("R5", "younger rejected", sq_pulse[0], 0);
        rob_done[0] = 1'b0;
        exsq(0, 8, 1, 1, 'h100); tick(); ex_sq_valid = '0;
        check("R6", "pulse", sq_pulse[0], 1);
        check("R6", "rollback incl", sseq(0), 7);
        check("R6", "pc", spc(0), 'h100);
        check("R9", "mispred fwd", sq_mispred[0], 1);
        check("R7", "status squashing", st(0), 2);
        check("R8", "count one", squash_count, 1);
        check("R8", "intake one sq", intake_en, 1);
        check("R9", "mcnt", mispred_cnt, 1);
        exsq(0, 5, 0, 0, 'h200); tick(); ex_sq_valid = '0;
        check("R5", "older accepted", sq_pulse[0], 1);
        check("R6", "rollback no incl", sseq(0), 5);
        exsq(0, 6, 0, 0, 'h300); tick(); ex_sq_valid = '0;
        check("R5", "younger than rollback rejected", sq_pulse[0], 0);
        check("R7", "flag held", rob_squashing[0], 1);
        tick();
        check("R7", "flag still held", rob_squashing[0], 1);
        check("R7", "still squashing", st(0), 2);
        rob_done[0] = 1'b1; tick();
        check("R7", "back to running", st(0), 1);
        check("R7", "flag dropped", rob_squashing[0], 0);
    endtask

    task automatic t_trap_latency();
        alloc(1, 20);
        rob_empty[1] = 1'b0;
        rob_head_seq[1*SEQ_W +: SEQ_W] = 15;
        arch_pc[1*PC_W +: PC_W] = 'h800;
        trap_lat = 3; trap_req[1] = 1'b1; tick(); trap_req = '0;
        check("R2", "trap wait status", st(1), 3);
        tick();
        check("R2", "no pulse e1", sq_pulse[1], 0);
        trap_req[1] = 1'b1; exsq(1, 1, 0, 1, 'h900); tick();
        trap_req = '0; ex_sq_valid = '0;
        check("R5", "exec ignored in trap wait", sq_pulse[1], 0);
        check("R2", "still waiting", st(1), 3);
        tick();
        check("R2", "no pulse e3", sq_pulse[1], 0);
        tick();
        check("R10", "retrigger did not restart", sq_pulse[1], 1);
        check("R4", "rollback head-1", sseq(1), 14);
        check("R4", "arch pc", spc(1), 'h800);
        check("R9", "trap no mispred", sq_mispred[1], 0);
        check("R9", "mcnt unchanged", mispred_cnt, 1);
        tick();
        check("R7", "trap squash done", st(1), 1);
    endtask

    task automatic t_ctx_empty();
        rob_empty[0] = 1'b1; arch_pc[0 +: PC_W] = 'h400;
        ctx_sq_req[0] = 1'b1; tick(); ctx_sq_req = '0;
        check("R4", "ctx not yet", sq_pulse[0], 0);
        tick();
        check("R4", "ctx pulse", sq_pulse[0], 1);
        check("R4", "empty rollback", sseq(0), 0);
        check("R4", "ctx pc", spc(0), 'h400);
        exsq(0, 1, 0, 0, 'h10); tick(); ex_sq_valid = '0;
        check("R4", "youngest reset rejects 1", sq_pulse[0], 0);
        exsq(0, 0, 0, 0, 'h20); tick(); ex_sq_valid = '0;
        check("R4", "youngest reset accepts 0", sq_pulse[0], 1);
        tick();
    endtask

    task automatic t_collide();
        trap_lat = 1; trap_fetch[1] = 1'b1; trap_req[1] = 1'b1; tick();
        trap_req = '0; trap_fetch = '0;
        check("R2", "fetch trap status", st(1), 4);
        ctx_sq_req[1] = 1'b1; tick(); ctx_sq_req = '0;
        check("R2", "no pulse yet", sq_pulse[1], 0);
        tick();
        check("R3", "trap first pulse", sq_pulse[1], 1);
        check("R3", "collision flag", both_err[1], 1);
        tick();
        check("R3", "ctx next pulse", sq_pulse[1], 1);
        check("R3", "flag cleared", both_err[1], 0);
        check("R3", "ctx rollback", sseq(1), 14);
        tick();
        check("R3", "quiet after", sq_pulse[1], 0);
    endtask

    task automatic t_all_squash();
        alloc(0, 40);
        alloc(1, 40);
        rob_done = '0;
        exsq(0, 30, 0, 1, 'h1); exsq(1, 30, 0, 1, 'h2); tick(); ex_sq_valid = '0;
        check("R8", "count all", squash_count, 2);
        check("R8", "intake off", intake_en, 0);
        check("R9", "mcnt two more", mispred_cnt, 3);
        rob_done = 2'b01; tick();
        check("R8", "count one left", squash_count, 1);
        check("R8", "intake back", intake_en, 1);
        rob_done = '1; tick();
        check("R8", "count zero", squash_count, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_exec_age();
        t_trap_latency();
        t_ctx_empty();
        t_collide();
        t_all_squash();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end
endmodule